// File: doc/BRIEF.md
# Multi-Rate Sample Interleaver

This block turns a stream of channel samples, arriving one per clock at the sampling rate, into 16-bit event words for a storage path that runs at a fixed word rate. A two-bit rate select sets how many consecutive samples share one word. At the single rate each sample of 16 channels becomes a word on its own. At the double rate two samples of 8 channels are packed together. At the quad rate four samples of 4 channels are packed together.

Inside a word the bits are grouped by channel, not by sample. All sample points of channel 0 sit in the lowest bits, followed by all sample points of channel 1, and so on. The earliest sample point takes the lowest bit of each channel group. The word is driven from a register and comes with a one-cycle valid pulse.

Top module: `sample_interleaver`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `word_vld` = 0 and `word_data` = 0. The phase count restarts and the remembered rate select becomes 2'b00.
- R2: The rate select is decoded as follows: 2'b00 is single rate, 2'b01 is double rate, 2'b10 is quad rate, and 2'b11 behaves exactly like single rate.
- R3: At single rate, each cycle with `smp_vld` high produces a word in the next cycle, with `word_data` equal to that cycle's `smp_data` and `word_vld` high.
- R4: At double rate, bit c of the p-th accepted sample (c = 0..7, p = 0 or 1) appears at bit 2*c+p of the word. The word is presented in the cycle after the second sample is accepted.
- R5: At quad rate, bit c of the p-th accepted sample (c = 0..3, p = 0..3, with p = 0 the earliest) appears at bit 4*c+p of the word. The word is presented in the cycle after the fourth sample is accepted.
- R6: `word_vld` is high for exactly one cycle per completed word. It is never high unless `smp_vld` was high in the previous cycle.
- R7: Cycles with `smp_vld` low do not advance the phase. The samples of one word need not arrive in consecutive cycles.
- R8: In any cycle where `rate_sel` differs from its value in the previous cycle, the partially collected word is discarded. If a sample is present in that cycle, it becomes phase 0 of the new rate.
- R9: Channel inputs that the current rate does not use have no effect. These are `smp_data[15:8]` at double rate and `smp_data[15:4]` at quad rate.
- R10: `word_data` keeps its value in every cycle where `word_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate select: 00 single, 01 double, 10 quad, 11 single |
| smp_vld | input | 1 | A sample is present on `smp_data` this cycle |
| smp_data | input | 16 | Channel sample, channel c on bit c |
| word_vld | output | 1 | One-cycle pulse marking a completed word |
| word_data | output | 16 | Packed event word |

## Verification
On every cycle the assertions check the following: the reset state, the single-rate pass-through and its one-cycle latency, that no valid pulse appears without a sample in the previous cycle, that a change of rate cannot complete a multi-sample word, and that the word holds between pulses. Some behaviour depends on the order of several samples: the per-channel bit placement at double and quad rate, gaps between samples, unused upper channels and partial words abandoned mid-way. Only the bench's scenarios can show these, by comparing the outputs with its queue-based model on every clock.

// File: rtl/interleave_pkg.sv
package interleave_pkg;

  typedef enum logic [1:0] {
    RATE_X1     = 2'b00,
    RATE_X2     = 2'b01,
    RATE_X4     = 2'b10,
    RATE_X1_ALT = 2'b11
  } rate_e;

  localparam int unsigned MAX_LOG = 2;
  localparam int unsigned PH_W    = MAX_LOG;

  // log2 of samples per word for a rate select
  function automatic logic [1:0] rate_log2(input logic [1:0] sel);
    case (sel)
      RATE_X2: rate_log2 = 2'd1;
      RATE_X4: rate_log2 = 2'd2;
      default: rate_log2 = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/phase_track.sv
module phase_track
  import interleave_pkg::*;
#(
  parameter int unsigned PW = PH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rate_sel,
  input  logic          smp_vld,
  output logic [PW-1:0] cur_phase,
  output logic          first_ph,
  output logic          last_ph
);

  logic [1:0]    sel_q;
  logic [PW-1:0] phase_q;
  logic          sel_chg;
  logic [PW-1:0] top_ph;

  assign sel_chg   = (rate_sel != sel_q);
  assign cur_phase = sel_chg ? '0 : phase_q;
  assign top_ph    = PW'((1 << rate_log2(rate_sel)) - 1);
  assign first_ph  = (cur_phase == '0);
  assign last_ph   = (cur_phase == top_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 2'b00;
      phase_q <= '0;
    end else begin
      sel_q <= rate_sel;
      if (smp_vld) phase_q <= last_ph ? '0 : cur_phase + 1'b1;
      else         phase_q <= cur_phase;
    end
  end

endmodule

// File: rtl/lane_spread.sv
module lane_spread #(
  parameter int unsigned W     = 16,
  parameter int unsigned RATIO = 1,
  parameter int unsigned PW    = 2,
  localparam int unsigned LANES = W / RATIO
) (
  input  logic [LANES-1:0] lanes,
  input  logic [PW-1:0]    phase,
  output logic [W-1:0]     spread
);

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    for (genvar p = 0; p < RATIO; p++) begin : g_ph
      assign spread[RATIO*c + p] = (phase == PW'(p)) & lanes[c];
    end
  end

endmodule

// File: rtl/word_pack.sv
module word_pack #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic         first_ph,
  input  logic         last_ph,
  input  logic [W-1:0] spread,
  output logic         word_vld,
  output logic [W-1:0] word_data
);

  logic [W-1:0] acc_q;
  logic [W-1:0] merged;

  assign merged = (first_ph ? '0 : acc_q) | spread;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= smp_vld & last_ph;
      if (smp_vld) begin
        acc_q <= merged;
        if (last_ph) word_data <= merged;
      end
    end
  end

endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver
  import interleave_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rate_sel,
  input  logic              smp_vld,
  input  logic [WORD_W-1:0] smp_data,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data
);

  localparam int unsigned NVAR = MAX_LOG + 1;

  logic [PH_W-1:0]   cur_phase;
  logic              first_ph, last_ph;
  logic [WORD_W-1:0] spread_v [NVAR];
  logic [WORD_W-1:0] spread_sel;

  phase_track #(.PW(PH_W)) u_phase (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_vld(smp_vld),
    .cur_phase(cur_phase), .first_ph(first_ph), .last_ph(last_ph)
  );

  for (genvar k = 0; k < NVAR; k++) begin : g_rate
    localparam int unsigned R = 1 << k;
    lane_spread #(.W(WORD_W), .RATIO(R), .PW(PH_W)) u_spread (
      .lanes (smp_data[WORD_W/R-1:0]),
      .phase (cur_phase),
      .spread(spread_v[k])
    );
  end

  assign spread_sel = spread_v[rate_log2(rate_sel)];

  word_pack #(.W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .first_ph(first_ph), .last_ph(last_ph), .spread(spread_sel),
    .word_vld(word_vld), .word_data(word_data)
  );

endmodule

// File: rtl/sample_interleaver_chk.sv
module sample_interleaver_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        rate_sel,
  input logic              smp_vld,
  input logic [WORD_W-1:0] smp_data,
  input logic              word_vld,
  input logic [WORD_W-1:0] word_data
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!word_vld && word_data == '0));

  // R3
  single_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (rate_sel == 2'b00 || rate_sel == 2'b11))
      |=> (word_vld && word_data == $past(smp_data)));

  // R6
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !word_vld);

  // R8
  rate_switch_chk: assert property (@(posedge clk) disable iff (rst)
    ((rate_sel != $past(rate_sel)) && (rate_sel == 2'b01 || rate_sel == 2'b10))
      |=> !word_vld);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_data));

endmodule

bind sample_interleaver sample_interleaver_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_vld(smp_vld),
  .smp_data(smp_data), .word_vld(word_vld), .word_data(word_data)
);

// File: tb/sample_interleaver_bench.sv
module sample_interleaver_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rate_sel = 2'b00;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_data = '0;
  logic        word_vld;
  logic [15:0] word_data;

  int vectors = 0;
  int misses  = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  sample_interleaver u_sample_interleaver (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_vld(smp_vld),
    .smp_data(smp_data), .word_vld(word_vld), .word_data(word_data)
  );

  // behavioural reference model
  logic [15:0] q[$];
  logic [1:0]  prev_sel = 2'b00;
  logic        exp_vld  = 1'b0;
  logic [15:0] exp_word = '0;

  function automatic int ratio_of(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); prev_sel = 2'b00; exp_vld = 0; exp_word = '0;
    end else begin
      int r;
      r = ratio_of(rate_sel);
      if (rate_sel != prev_sel) q.delete();
      prev_sel = rate_sel;
      exp_vld = 0;
      if (smp_vld) q.push_back(smp_data);
      if (q.size() == r) begin
        logic [15:0] w;
        w = '0;
        for (int c = 0; c < 16 / r; c++)
          for (int p = 0; p < r; p++)
            w[r*c + p] = q[p][c];
        exp_word = w;
        exp_vld = 1;
        q.delete();
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (word_vld !== exp_vld || word_data !== exp_word) begin
        misses++;
        $display("FAIL %s: vld=%0b word=%04h expected vld=%0b word=%04h",
                 cur_req, word_vld, word_data, exp_vld, exp_word);
      end
    end
  end

  task automatic put(input logic v, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    smp_vld = v; rate_sel = s; smp_data = d;
  endtask

  initial begin
    // R1: reset state checked by the per-cycle compare
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 0;
    // R3: single rate pass-through
    cur_req = "R3";
    put(1, 2'b00, 16'hA5C3); put(1, 2'b00, 16'h0001); put(1, 2'b00, 16'hFFFF);
    put(0, 2'b00, 16'h1234);
    // R2: code 11 acts as single rate
    cur_req = "R2";
    put(1, 2'b11, 16'h8001); put(1, 2'b11, 16'h7E7E); put(0, 2'b11, 16'h0);
    // R4: double-rate interleave
    cur_req = "R4";
    put(1, 2'b01, 16'h00F0); put(1, 2'b01, 16'h000F);
    put(1, 2'b01, 16'h00AA); put(1, 2'b01, 16'h0055);
    // R9: upper channels ignored at double rate
    cur_req = "R9";
    put(1, 2'b01, 16'hFF81); put(1, 2'b01, 16'h5A18);
    // R5: quad-rate interleave
    cur_req = "R5";
    put(1, 2'b10, 16'h0001); put(1, 2'b10, 16'h0002);
    put(1, 2'b10, 16'h0004); put(1, 2'b10, 16'h0008);
    put(1, 2'b10, 16'hFFF9); put(1, 2'b10, 16'hABC6);
    put(1, 2'b10, 16'h123F); put(1, 2'b10, 16'h0000);
    // R7: gaps between samples
    cur_req = "R7";
    put(1, 2'b10, 16'h0003); put(0, 2'b10, 16'hFFFF); put(1, 2'b10, 16'h000C);
    put(0, 2'b10, 16'h0); put(0, 2'b10, 16'h0);
    put(1, 2'b10, 16'h0005); put(1, 2'b10, 16'h000A); put(0, 2'b10, 16'h0);
    // R8: switch mid-word discards the partial word
    cur_req = "R8";
    put(1, 2'b10, 16'h000F); put(1, 2'b10, 16'h000F);
    put(1, 2'b01, 16'h0011); put(1, 2'b01, 16'h0022);
    put(1, 2'b01, 16'h0033); put(0, 2'b10, 16'h0);
    put(1, 2'b10, 16'h0001); put(1, 2'b00, 16'hBEEF);
    // R6 / R10: stream of random traffic, holds and single pulses
    cur_req = "R6";
    for (int i = 0; i < 200; i++) begin
      logic [1:0] s;
      s = (i % 50 < 20) ? 2'b10 : (i % 50 < 40) ? 2'b01 : 2'($urandom_range(0, 3));
      put(1'($urandom_range(0, 1)), s, 16'($urandom));
    end
    cur_req = "R10";
    put(0, 2'b01, 16'h0); repeat (3) put(0, 2'b01, 16'($urandom));
    // R1: reset mid-word
    cur_req = "R1";
    put(1, 2'b10, 16'h000F);
    @(negedge clk); rst = 1; smp_vld = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    put(1, 2'b10, 16'h0001); put(1, 2'b10, 16'h0); put(1, 2'b10, 16'h0);
    put(1, 2'b10, 16'h0); put(0, 2'b10, 16'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule